// File: doc/BRIEF.md
# Per-Hart Timer and Message IPI Unit

This block sits beside one processor core. It keeps a 64-bit time base and one 64-bit compare register for each of the four privilege levels (machine, hypervisor, supervisor and user). A per-level enable decides whether a level's comparator may raise that level's timer-pending line.

It also keeps one 64-bit message word per privilege level. Another core raises a software interrupt at a level by storing a nonzero code into that level's word. Code 1, for instance, could mean a translation-cache shoot-down. The receiving core reads the word to learn the reason, then stores zero to drop the interrupt. Local software reaches every register through a word-indexed register port. Remote cores reach the message words through a separate write-only port.

The parameter `LOWER_LEVELS` keeps or removes the hypervisor, supervisor and user registers. The machine-level registers are always built.

Top module: `hart_local_irq`

## Requirements
- R1: After synchronous reset the time base is 0, every compare register is all ones, every message word is 0, all timer enables are 0, and both pending outputs are 0.
- R2: The time base rises by exactly one on every clock edge at which `tick_en` is high, and holds its value otherwise.
- R3: A register-port write to index 0 loads the time base. In a cycle where that write and a tick coincide, the written value wins.
- R4: Bit l of `tmr_pend` is high when the time base is greater than or equal to compare register l and enable bit l is set. Bit order for all per-level vectors is 0 = machine, 1 = hypervisor, 2 = supervisor, 3 = user. A write to a compare register or to the time base is reflected at the output in the cycle after the write edge.
- R5: With enable bit l cleared, `tmr_pend[l]` stays low whatever the compare result. The enables live at index 9, bits 3:0 in level order.
- R6: Bit l of `sw_pend` is high exactly when message word l holds any nonzero value, including a value with only bit 63 set. A local write of zero clears it.
- R7: A remote write (`rmt_wr`, `rmt_lvl`, `rmt_wdata`) stores its data into message word `rmt_lvl`. If a local write targets the same word in the same cycle, the remote data is kept. A local write to a different register in that cycle still takes effect.
- R8: A read request on `reg_rd` returns the register at `reg_idx` on `reg_rdata`, with `reg_rvld` high, one cycle later. The index map is: 0 time base, 1 to 4 compare registers, 5 to 8 message words (both in level order), and 9 enables.
- R9: Indices 10 to 15 read as zero, and writes to them change no register or output.
- R10: With `LOWER_LEVELS` = 0, the hypervisor, supervisor and user compare registers, message words and enable bits read as zero. Writes and remote writes to them are ignored, and their pending outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the time base this cycle |
| reg_wr | input | 1 | Local register write strobe |
| reg_rd | input | 1 | Local register read strobe |
| reg_idx | input | 4 | Word index of the register accessed |
| reg_wdata | input | 64 | Local write data |
| reg_rdata | output | 64 | Read data, valid with `reg_rvld` |
| reg_rvld | output | 1 | Read data valid, one cycle after `reg_rd` |
| rmt_wr | input | 1 | Remote message-word write strobe |
| rmt_lvl | input | 2 | Target level of the remote write |
| rmt_wdata | input | 64 | Remote message code |
| tmr_pend | output | 4 | Timer-pending line per level |
| sw_pend | output | 4 | Software-pending line per level |

## Verification
Every register write lands on the clock edge that samples it. `tmr_pend` and `sw_pend` are combinational from the registers, so they are due one cycle after the stimulus. The bench therefore drives on a falling edge and checks the pending lines on the very next falling edge. Read data is registered once, so each read pushes its expected value into a queue. A monitor pops and compares that entry on the falling edge where `reg_rvld` is high, one cycle after the request. Time-base reads are taken with `tick_en` low, so the expected count is the number of edges for which the bench held it high.

// File: rtl/hlu_pkg.sv
package hlu_pkg;

    localparam int NLV = 4;
    localparam int IXW = 4;

    typedef enum logic [1:0] {
        LV_MACH = 2'd0,
        LV_HYP  = 2'd1,
        LV_SUP  = 2'd2,
        LV_USR  = 2'd3
    } lvl_e;

    localparam logic [IXW-1:0] IX_TIME = 4'd0;
    localparam logic [IXW-1:0] IX_CMP0 = 4'd1;
    localparam logic [IXW-1:0] IX_MSG0 = 4'd5;
    localparam logic [IXW-1:0] IX_TEN  = 4'd9;

    typedef struct packed {
        logic           time_ld;
        logic           ten_ld;
        logic [NLV-1:0] cmp_ld;
        logic [NLV-1:0] msg_ld;
    } wr_dec_t;

    function automatic logic [IXW-1:0] cmp_ix(input int l);
        return IX_CMP0 + IXW'(l);
    endfunction

    function automatic logic [IXW-1:0] msg_ix(input int l);
        return IX_MSG0 + IXW'(l);
    endfunction

    function automatic wr_dec_t decode_wr(input logic we, input logic [IXW-1:0] ix);
        wr_dec_t d;
        d.time_ld = we && (ix == IX_TIME);
        d.ten_ld  = we && (ix == IX_TEN);
        for (int l = 0; l < NLV; l++) begin
            d.cmp_ld[l] = we && (ix == cmp_ix(l));
            d.msg_ld[l] = we && (ix == msg_ix(l));
        end
        return d;
    endfunction

    function automatic logic [NLV-1:0] level_mask(input bit lower);
        return lower ? {NLV{1'b1}} : {{(NLV-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/hlu_time_base.sv
module hlu_time_base #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst)       now <= '0;
        else if (load) now <= load_val;
        else if (tick) now <= now + 1'b1;
    end

    // R2: one step per tick
    a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (now == $past(now) + 1'b1));

    // R2: idle cycles hold the count
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(now));

    // R3: load overrides the tick
    a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (now == $past(load_val)));

endmodule

// File: rtl/hlu_cmp_slice.sv
module hlu_cmp_slice #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_wr,
    input  logic [DW-1:0] cmp_wdata,
    input  logic [DW-1:0] now,
    input  logic          en,
    output logic [DW-1:0] cmp_q,
    output logic          pend
);

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '1;
        else if (cmp_wr) cmp_q <= cmp_wdata;
    end

    assign pend = en && (now >= cmp_q);

    // R4: a compare write is visible one edge later
    a_r4_cmp_update: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (cmp_q == $past(cmp_wdata)));

endmodule

// File: rtl/hlu_msg_slot.sv
module hlu_msg_slot #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lcl_wr,
    input  logic [DW-1:0] lcl_data,
    input  logic          rmt_wr,
    input  logic [DW-1:0] rmt_data,
    output logic [DW-1:0] word,
    output logic          pend
);

    always_ff @(posedge clk) begin
        if (rst)         word <= '0;
        else if (rmt_wr) word <= rmt_data;
        else if (lcl_wr) word <= lcl_data;
    end

    assign pend = |word;

    // R7: remote data survives a same-cycle local write
    a_r7_remote_wins: assert property (@(posedge clk) disable iff (rst)
        rmt_wr |=> (word == $past(rmt_data)));

    // R6: a lone local write stores its data
    a_r6_local_store: assert property (@(posedge clk) disable iff (rst)
        (lcl_wr && !rmt_wr) |=> (word == $past(lcl_data)));

endmodule

// File: rtl/hart_local_irq.sv
module hart_local_irq #(
    parameter int DW           = 64,
    parameter bit LOWER_LEVELS = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_en,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [hlu_pkg::IXW-1:0] reg_idx,
    input  logic [DW-1:0]           reg_wdata,
    output logic [DW-1:0]           reg_rdata,
    output logic                    reg_rvld,
    input  logic                    rmt_wr,
    input  logic [1:0]              rmt_lvl,
    input  logic [DW-1:0]           rmt_wdata,
    output logic [hlu_pkg::NLV-1:0] tmr_pend,
    output logic [hlu_pkg::NLV-1:0] sw_pend
);
    import hlu_pkg::*;

    localparam int             IMPL  = LOWER_LEVELS ? NLV : 1;
    localparam logic [NLV-1:0] LMASK = level_mask(LOWER_LEVELS);

    wr_dec_t        wdec;
    logic [DW-1:0]  now;
    logic [NLV-1:0] ten_q;
    logic [DW-1:0]  cmp_q [NLV];
    logic [DW-1:0]  msg_q [NLV];
    logic [DW-1:0]  rd_mux;

    assign wdec = decode_wr(reg_wr, reg_idx);

    hlu_time_base #(.DW(DW)) u_time (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .load     (wdec.time_ld),
        .load_val (reg_wdata),
        .now      (now)
    );

    always_ff @(posedge clk) begin
        if (rst)              ten_q <= '0;
        else if (wdec.ten_ld) ten_q <= reg_wdata[NLV-1:0] & LMASK;
    end

    for (genvar l = 0; l < NLV; l++) begin : g_lvl
        if (l < IMPL) begin : g_on
            hlu_cmp_slice #(.DW(DW)) u_cmp (
                .clk       (clk),
                .rst       (rst),
                .cmp_wr    (wdec.cmp_ld[l]),
                .cmp_wdata (reg_wdata),
                .now       (now),
                .en        (ten_q[l]),
                .cmp_q     (cmp_q[l]),
                .pend      (tmr_pend[l])
            );
            hlu_msg_slot #(.DW(DW)) u_msg (
                .clk      (clk),
                .rst      (rst),
                .lcl_wr   (wdec.msg_ld[l]),
                .lcl_data (reg_wdata),
                .rmt_wr   (rmt_wr && (rmt_lvl == 2'(l))),
                .rmt_data (rmt_wdata),
                .word     (msg_q[l]),
                .pend     (sw_pend[l])
            );

            // R5: a disabled level never shows timer pending
            a_r5_gate: assert property (@(posedge clk) disable iff (rst)
                !ten_q[l] |-> !tmr_pend[l]);

            // R6: clearing the word drops the software line
            a_r6_clear: assert property (@(posedge clk) disable iff (rst)
                (wdec.msg_ld[l] && (reg_wdata == '0) && !(rmt_wr && (rmt_lvl == 2'(l))))
                |=> !sw_pend[l]);
        end else begin : g_off
            assign cmp_q[l]    = '0;
            assign msg_q[l]    = '0;
            assign tmr_pend[l] = 1'b0;
            assign sw_pend[l]  = 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_idx == IX_TIME) rd_mux = now;
        if (reg_idx == IX_TEN)  rd_mux = {{(DW-NLV){1'b0}}, ten_q};
        for (int l = 0; l < NLV; l++) begin
            if (reg_idx == cmp_ix(l)) rd_mux = cmp_q[l];
            if (reg_idx == msg_ix(l)) rd_mux = msg_q[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            reg_rvld  <= 1'b0;
        end else begin
            reg_rvld <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    // R8: read data arrives one cycle after the request
    a_r8_rd_latency: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvld);

    // R9: indices past the map read as zero
    a_r9_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_idx > IX_TEN)) |=> (reg_rdata == '0));

    if (!LOWER_LEVELS) begin : g_r10
        // R10: absent levels stay quiet
        a_r10_absent_quiet: assert property (@(posedge clk) disable iff (rst)
            (tmr_pend[NLV-1:1] == '0) && (sw_pend[NLV-1:1] == '0) && (ten_q[NLV-1:1] == '0));
    end

endmodule

// File: tb/test_hart_local_irq.sv
`timescale 1ns/1ps
module test_hart_local_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic        rmt_wr = 1'b0;
    logic [1:0]  rmt_lvl = '0;
    logic [63:0] rmt_wdata = '0;
    logic [63:0] reg_rdata, sec_rdata;
    logic        reg_rvld, sec_rvld;
    logic [3:0]  tmr_pend, sw_pend, sec_tmr, sec_sw;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] q_exp [$];
    string       q_tag [$];

    always #2 clk = ~clk;

    hart_local_irq i_hart_local_irq (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvld(reg_rvld),
        .rmt_wr(rmt_wr), .rmt_lvl(rmt_lvl), .rmt_wdata(rmt_wdata),
        .tmr_pend(tmr_pend), .sw_pend(sw_pend)
    );

    hart_local_irq #(.LOWER_LEVELS(1'b0)) i_hart_local_irq_m (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(sec_rdata), .reg_rvld(sec_rvld),
        .rmt_wr(rmt_wr), .rmt_lvl(rmt_lvl), .rmt_wdata(rmt_wdata),
        .tmr_pend(sec_tmr), .sw_pend(sec_sw)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected read result per valid cycle
    always @(negedge clk) begin
        if (!rst && reg_rvld) begin
            if (q_exp.size() == 0) chk(1'b1, 1'b0, "R8 unexpected read data");
            else chk(reg_rdata, q_exp.pop_front(), q_tag.pop_front());
        end
    end

    task automatic wr(input logic [3:0] ix, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = ix; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rwr(input logic [1:0] lv, input logic [63:0] d);
        @(negedge clk);
        rmt_wr = 1'b1; rmt_lvl = lv; rmt_wdata = d;
        @(negedge clk);
        rmt_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ix, input logic [63:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = ix;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(tmr_pend, 4'h0, "R1 tmr_pend");
        chk(sw_pend, 4'h0, "R1 sw_pend");
        rd(4'd0, 64'd0, "R1 time");
        rd(4'd1, '1, "R1 cmp M");
        rd(4'd4, '1, "R1 cmp U");
        rd(4'd5, 64'd0, "R1 msg M");
        rd(4'd9, 64'd0, "R1 enables");

        // R2 counting
        @(negedge clk); tick_en = 1'b1;
        repeat (9) @(negedge clk);
        tick_en = 1'b0;
        rd(4'd0, 64'd9, "R2 count after 9 ticks");
        rd(4'd0, 64'd9, "R2 hold without tick");

        // R3 load beats tick
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 4'd0; reg_wdata = 64'd1000; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        rd(4'd0, 64'd1000, "R3 loaded time");

        // R4 / R5 comparator boundaries
        wr(4'd1, 64'd1005);
        wr(4'd9, 64'h1);
        chk(tmr_pend, 4'h0, "R4 below compare");
        wr(4'd0, 64'd1004);
        chk(tmr_pend, 4'h0, "R4 one below compare");
        wr(4'd0, 64'd1005);
        chk(tmr_pend, 4'h1, "R4 equal compare");
        wr(4'd1, 64'd2000);
        chk(tmr_pend, 4'h0, "R4 compare raised");
        wr(4'd1, 64'd1005);
        chk(tmr_pend, 4'h1, "R4 compare lowered");
        wr(4'd9, 64'h0);
        chk(tmr_pend, 4'h0, "R5 enable cleared");
        wr(4'd3, 64'd10);
        chk(tmr_pend, 4'h0, "R5 S disabled");
        wr(4'd9, 64'h4);
        chk(tmr_pend, 4'h4, "R4 S above compare");
        chk(sec_tmr, 4'h0, "R10 S timer absent");
        rd(4'd3, 64'd10, "R8 cmp S readback");
        chk(sec_rdata, 64'd0, "R10 cmp S reads zero");
        rd(4'd9, 64'h4, "R8 enables readback");
        chk(sec_rdata, 64'd0, "R10 enable S bit dropped");

        // R6 message words
        wr(4'd7, 64'd1);
        chk(sw_pend, 4'h4, "R6 S message raises");
        chk(sec_sw, 4'h0, "R10 S message absent");
        rd(4'd7, 64'd1, "R6 message code");
        wr(4'd7, 64'd0);
        chk(sw_pend, 4'h0, "R6 cleared");
        wr(4'd5, 64'h8000_0000_0000_0000);
        chk(sw_pend, 4'h1, "R6 top bit only");
        chk(sec_sw, 4'h1, "R10 M still present");
        wr(4'd5, 64'd0);
        chk(sw_pend, 4'h0, "R6 M cleared");

        // R7 remote writes and collisions
        rwr(2'd1, 64'h42);
        chk(sw_pend, 4'h2, "R7 remote raises H");
        chk(sec_sw, 4'h0, "R10 remote H ignored");
        rd(4'd6, 64'h42, "R7 remote code");
        chk(sec_rdata, 64'd0, "R10 msg H reads zero");
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 4'd5; reg_wdata = 64'd7;
        rmt_wr = 1'b1; rmt_lvl = 2'd0; rmt_wdata = 64'd2;
        @(negedge clk);
        reg_wr = 1'b0; rmt_wr = 1'b0;
        rd(4'd5, 64'd2, "R7 remote wins on M");
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 4'd6; reg_wdata = 64'd0;
        rmt_wr = 1'b1; rmt_lvl = 2'd1; rmt_wdata = 64'd9;
        @(negedge clk);
        reg_wr = 1'b0; rmt_wr = 1'b0;
        chk(sw_pend, 4'h3, "R7 local clear lost to remote");
        rd(4'd6, 64'd9, "R7 remote wins on H");
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 4'd8; reg_wdata = 64'd3;
        rmt_wr = 1'b1; rmt_lvl = 2'd0; rmt_wdata = 64'd5;
        @(negedge clk);
        reg_wr = 1'b0; rmt_wr = 1'b0;
        rd(4'd8, 64'd3, "R7 local to other word kept");
        rd(4'd5, 64'd5, "R7 remote to M kept");

        // R9 holes
        wr(4'd12, '1);
        chk(sw_pend, 4'hB, "R9 hole write no effect sw");
        chk(tmr_pend, 4'h4, "R9 hole write no effect tmr");
        rd(4'd12, 64'd0, "R9 index 12 zero");
        rd(4'd15, 64'd0, "R9 index 15 zero");
        rd(4'd0, 64'd1005, "R9 time untouched");

        @(negedge clk); @(negedge clk);
        chk(q_exp.size(), 0, "R8 all reads answered");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule